// File: doc/BRIEF.md
# Decimal Up/Down Event Tally with Preset Comparison

The block counts events from three asynchronous field lines: one pulse train that steps the tally up, one that steps it down, and a line that clears it. Each line passes through a two-flop synchroniser, and only its rising edge has any effect. The tally is kept as four packed BCD digits, so it runs from 0000 to 9999 and wraps in decimal at both ends. The current value can drive a decimal display directly.

A host writes through two load strobes that share one data bus. One strobe replaces the tally and the other replaces the preset. A load is refused when any of its digits is above nine. Three comparison flags state at all times whether the tally is above, equal to or below the preset.

A sticky carry/borrow flag marks a full pass through zero across a wrap. It is set only when the tally moves 9999, 0000, 0001 upward, or 0001, 0000, 9999 downward. The host clears it with an acknowledge strobe.

Top module: `bcd_tally`

## Requirements
- R1: After reset the tally and the preset both read 0000, the carry/borrow flag is 0 and the equal flag is 1.
- R2: A rising edge on `incIn` adds one to the tally with decimal digit carry. The new value shows three clock edges after the line is first sampled high. Holding the line high adds nothing further.
- R3: A rising edge on `decIn` subtracts one from the tally with decimal digit borrow, on the same timing as R2.
- R4: An up edge is ignored while `decIn` or `clrIn` is high. A down edge is ignored while `incIn` or `clrIn` is high. Up and down edges that arrive together are both ignored.
- R5: A rising edge on `clrIn` sets the tally to 0000, whatever the levels of the other two lines.
- R6: Stepping up from 9999 gives 0000, and stepping down from 0000 gives 9999. Every digit of the tally stays in the range 0 to 9.
- R7: The carry/borrow flag goes to 1 on an up step out of 0000 when the tally reached 0000 by an up wrap. It also goes to 1 on a down step out of 0000 when the tally reached 0000 by a down step from 0001. Any other way into or out of 0000 leaves the flag unchanged. Once set, the flag holds until a cycle with `borrowAck` high. If a set and an acknowledge fall in the same cycle, the set wins.
- R8: A `loadCurStb` cycle with a valid BCD `loadValue` puts that value on the tally after one edge. If any 4-bit digit of the value is above 9, the tally keeps its old value.
- R9: A `loadPreStb` cycle with a valid BCD `loadValue` puts that value on the preset after one edge. If any digit is above 9, the preset keeps its old value.
- R10: Exactly one of `gtFlag`, `eqFlag` and `ltFlag` is high. They compare the tally with the preset as decimal numbers, in the same cycle.
- R11: In a cycle with `loadCurStb` high, a count or clear edge that falls due is dropped. This holds even when the load itself is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| incIn | input | 1 | Up pulse line, asynchronous |
| decIn | input | 1 | Down pulse line, asynchronous |
| clrIn | input | 1 | Clear line, asynchronous |
| loadCurStb | input | 1 | Load tally from `loadValue` |
| loadPreStb | input | 1 | Load preset from `loadValue` |
| loadValue | input | 16 | Packed BCD value for either load |
| borrowAck | input | 1 | Clears the carry/borrow flag |
| curValue | output | 16 | Tally, packed BCD |
| presetValue | output | 16 | Preset, packed BCD |
| gtFlag | output | 1 | Tally above preset |
| eqFlag | output | 1 | Tally equal to preset |
| ltFlag | output | 1 | Tally below preset |
| carryFlag | output | 1 | Sticky carry/borrow |

## Verification
A field line driven high is seen in the tally three clock edges later. That is two synchroniser flops plus the tally register. Host loads and acknowledges are seen one edge later, and the comparison flags follow the tally in the same cycle. The driver tasks record the cycle in which each result becomes due and queue the expected tally, preset and flag values for it. The monitor compares them on the falling edge of that cycle. To show that a held line does not step twice, a second item is queued a few cycles after the first one. The load-versus-step collision is driven so that the load strobe falls exactly on the edge where the step would register.

// File: rtl/tally_pkg.sv
package tally_pkg;

  // Strobes from the control module to the datapath, one cycle each.
  typedef struct packed {
    logic incStep;
    logic decStep;
    logic clrStep;
    logic loadCur;
    logic loadPre;
    logic ack;
  } step_t;

  // How the tally last arrived at zero.
  typedef enum logic [1:0] {
    ENTRY_NONE = 2'd0,
    ENTRY_UP   = 2'd1,
    ENTRY_DOWN = 2'd2
  } zeroEntry_t;

endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  incIn,
  input  logic  decIn,
  input  logic  clrIn,
  input  logic  loadCurStb,
  input  logic  loadPreStb,
  input  logic  borrowAck,
  output step_t cmd
);

  localparam int CHANNELS = 3;
  localparam int CH_INC = 0;
  localparam int CH_DEC = 1;
  localparam int CH_CLR = 2;

  logic [CHANNELS-1:0] rawLine;
  logic [CHANNELS-1:0] syncLevel;
  logic [CHANNELS-1:0] prevLevel;
  logic [CHANNELS-1:0] riseEdge;

  assign rawLine = {clrIn, decIn, incIn};

  // One synchroniser chain per field line
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawLine[ch]};
    end
    assign syncLevel[ch] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= syncLevel;
  end

  assign riseEdge = syncLevel & ~prevLevel;

  // A host tally load masks every field action in its cycle.
  always_comb begin
    cmd.loadCur = loadCurStb;
    cmd.loadPre = loadPreStb;
    cmd.ack     = borrowAck;
    cmd.clrStep = riseEdge[CH_CLR] & ~loadCurStb;
    cmd.incStep = riseEdge[CH_INC] & ~syncLevel[CH_DEC] & ~syncLevel[CH_CLR]
                  & ~loadCurStb;
    cmd.decStep = riseEdge[CH_DEC] & ~syncLevel[CH_INC] & ~syncLevel[CH_CLR]
                  & ~loadCurStb;
  end

endmodule

// File: rtl/tally_datapath.sv
module tally_datapath
  import tally_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  step_t               cmd,
  input  logic [4*DIGITS-1:0] loadValue,
  output logic [4*DIGITS-1:0] curValue,
  output logic [4*DIGITS-1:0] presetValue,
  output logic                gtFlag,
  output logic                eqFlag,
  output logic                ltFlag,
  output logic                carryFlag
);

  localparam int W = 4 * DIGITS;

  function automatic logic bcdOk(input logic [W-1:0] v);
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    end
    return 1'b1;
  endfunction

  logic [W-1:0]    upValue;
  logic [W-1:0]    downValue;
  logic [DIGITS:0] upCarry;
  logic [DIGITS:0] downBorrow;
  logic            loadOk;
  logic            presetOk;
  logic            curIsZero;
  logic            upWraps;
  logic            downReachesZero;
  logic            setCarry;
  zeroEntry_t      entry;

  assign upCarry[0]    = 1'b1;
  assign downBorrow[0] = 1'b1;

  // Decimal increment and decrement, one digit slice per stage
  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [3:0] digit;
    assign digit = curValue[4*g +: 4];
    assign upValue[4*g +: 4]   = !upCarry[g] ? digit :
                                 (digit == 4'd9) ? 4'd0 : digit + 4'd1;
    assign downValue[4*g +: 4] = !downBorrow[g] ? digit :
                                 (digit == 4'd0) ? 4'd9 : digit - 4'd1;
    assign upCarry[g+1]    = upCarry[g] & (digit == 4'd9);
    assign downBorrow[g+1] = downBorrow[g] & (digit == 4'd0);
  end

  assign upWraps         = upCarry[DIGITS];
  assign curIsZero       = downBorrow[DIGITS];
  assign downReachesZero = (downValue == '0);
  assign loadOk          = bcdOk(loadValue);
  assign presetOk        = loadOk;

  assign setCarry = (cmd.incStep && curIsZero && entry == ENTRY_UP) ||
                    (cmd.decStep && curIsZero && entry == ENTRY_DOWN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValue <= '0;
      entry    <= ENTRY_NONE;
    end else if (cmd.loadCur) begin
      if (loadOk) begin
        curValue <= loadValue;
        entry    <= ENTRY_NONE;
      end
    end else if (cmd.clrStep) begin
      curValue <= '0;
      entry    <= ENTRY_NONE;
    end else if (cmd.incStep) begin
      curValue <= upValue;
      entry    <= upWraps ? ENTRY_UP : ENTRY_NONE;
    end else if (cmd.decStep) begin
      curValue <= downValue;
      entry    <= downReachesZero ? ENTRY_DOWN : ENTRY_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      presetValue <= '0;
    else if (cmd.loadPre && presetOk) presetValue <= loadValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         carryFlag <= 1'b0;
    else if (setCarry) carryFlag <= 1'b1;
    else if (cmd.ack)  carryFlag <= 1'b0;
  end

  // Valid packed BCD orders the same way as the unsigned number.
  always_comb begin
    gtFlag = curValue > presetValue;
    ltFlag = curValue < presetValue;
    eqFlag = !gtFlag && !ltFlag;
  end

endmodule

// File: rtl/bcd_tally.sv
module bcd_tally
  import tally_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                incIn,
  input  logic                decIn,
  input  logic                clrIn,
  input  logic                loadCurStb,
  input  logic                loadPreStb,
  input  logic [4*DIGITS-1:0] loadValue,
  input  logic                borrowAck,
  output logic [4*DIGITS-1:0] curValue,
  output logic [4*DIGITS-1:0] presetValue,
  output logic                gtFlag,
  output logic                eqFlag,
  output logic                ltFlag,
  output logic                carryFlag
);

  step_t cmd;

  tally_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .incIn      (incIn),
    .decIn      (decIn),
    .clrIn      (clrIn),
    .loadCurStb (loadCurStb),
    .loadPreStb (loadPreStb),
    .borrowAck  (borrowAck),
    .cmd        (cmd)
  );

  tally_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .loadValue   (loadValue),
    .curValue    (curValue),
    .presetValue (presetValue),
    .gtFlag      (gtFlag),
    .eqFlag      (eqFlag),
    .ltFlag      (ltFlag),
    .carryFlag   (carryFlag)
  );

endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                loadCurStb,
  input logic                loadPreStb,
  input logic [4*DIGITS-1:0] loadValue,
  input logic                borrowAck,
  input logic [4*DIGITS-1:0] curValue,
  input logic [4*DIGITS-1:0] presetValue,
  input logic                gtFlag,
  input logic                eqFlag,
  input logic                ltFlag,
  input logic                carryFlag
);

  localparam int W = 4 * DIGITS;

  function automatic logic digitsOk(input logic [W-1:0] v);
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] allNines();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[4*i +: 4] = 4'd9;
    return v;
  endfunction

  p_digits_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    digitsOk(curValue) && digitsOk(presetValue));

  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({gtFlag, eqFlag, ltFlag}));

  p_cur_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadCurStb && digitsOk(loadValue) |=> curValue == $past(loadValue));

  p_cur_reject_r11: assert property (@(posedge clk) disable iff (!rstN)
    loadCurStb && !digitsOk(loadValue) |=> $stable(curValue));

  p_pre_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadPreStb && digitsOk(loadValue) |=> presetValue == $past(loadValue));

  p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(loadPreStb && digitsOk(loadValue)) |=> $stable(presetValue));

  p_carry_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carryFlag) |-> $past(borrowAck));

  p_carry_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryFlag) |-> (curValue == W'(1)) || (curValue == allNines()));

endmodule

bind bcd_tally tally_checker #(.DIGITS(DIGITS)) u_tally_checker (
  .clk         (clk),
  .rstN        (rstN),
  .loadCurStb  (loadCurStb),
  .loadPreStb  (loadPreStb),
  .loadValue   (loadValue),
  .borrowAck   (borrowAck),
  .curValue    (curValue),
  .presetValue (presetValue),
  .gtFlag      (gtFlag),
  .eqFlag      (eqFlag),
  .ltFlag      (ltFlag),
  .carryFlag   (carryFlag)
);

// File: tb/test_bcd_tally.sv
module test_bcd_tally;

  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 4;
  localparam int W          = 4 * DIGITS;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         incIn = 1'b0;
  logic         decIn = 1'b0;
  logic         clrIn = 1'b0;
  logic         loadCurStb = 1'b0;
  logic         loadPreStb = 1'b0;
  logic [W-1:0] loadValue = '0;
  logic         borrowAck = 1'b0;
  logic [W-1:0] curValue;
  logic [W-1:0] presetValue;
  logic         gtFlag;
  logic         eqFlag;
  logic         ltFlag;
  logic         carryFlag;

  bcd_tally #(.DIGITS(DIGITS)) i_bcd_tally (
    .clk         (clk),
    .rstN        (rstN),
    .incIn       (incIn),
    .decIn       (decIn),
    .clrIn       (clrIn),
    .loadCurStb  (loadCurStb),
    .loadPreStb  (loadPreStb),
    .loadValue   (loadValue),
    .borrowAck   (borrowAck),
    .curValue    (curValue),
    .presetValue (presetValue),
    .gtFlag      (gtFlag),
    .eqFlag      (eqFlag),
    .ltFlag      (ltFlag),
    .carryFlag   (carryFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    cur;
    int    pre;
    bit    carry;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // Reference model, in plain decimal
  int mCur = 0;
  int mPre = 0;
  bit mCarry = 1'b0;
  int mEntry = 0; // 0 none, 1 arrived by up wrap, 2 arrived by down step

  function automatic logic [W-1:0] toBcd(input int v);
    logic [W-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int fromBcd(input logic [W-1:0] v);
    int r;
    r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic bit bcdGood(input logic [W-1:0] v);
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAt(input int k, input string req);
    exp_t e;
    e.due = cyc + k;
    e.cur = mCur;
    e.pre = mPre;
    e.carry = mCarry;
    e.req = req;
    sbq.push_back(e);
  endtask

  task automatic mStep(input int dir);
    if (dir > 0) begin
      if (mCur == 0 && mEntry == 1) mCarry = 1'b1;
      mCur = (mCur + 1) % 10000;
      mEntry = (mCur == 0) ? 1 : 0;
    end else begin
      if (mCur == 0 && mEntry == 2) mCarry = 1'b1;
      mCur = (mCur + 9999) % 10000;
      mEntry = (mCur == 0) ? 2 : 0;
    end
  endtask

  // which: 0 up line, 1 down line, 2 clear line
  task automatic fieldPulse(input int which, input string req);
    case (which)
      0: begin incIn = 1'b1; mStep(1); end
      1: begin decIn = 1'b1; mStep(-1); end
      default: begin clrIn = 1'b1; mCur = 0; mEntry = 0; end
    endcase
    expectAt(3, req);
    expectAt(5, req); // held high: no second action
    waitN(6);
    incIn = 1'b0; decIn = 1'b0; clrIn = 1'b0;
    waitN(3);
  endtask

  task automatic hostCur(input logic [W-1:0] v, input string req);
    loadValue = v;
    loadCurStb = 1'b1;
    if (bcdGood(v)) begin mCur = fromBcd(v); mEntry = 0; end
    expectAt(1, req);
    waitN(1);
    loadCurStb = 1'b0;
    waitN(1);
  endtask

  task automatic hostPre(input logic [W-1:0] v, input string req);
    loadValue = v;
    loadPreStb = 1'b1;
    if (bcdGood(v)) mPre = fromBcd(v);
    expectAt(1, req);
    waitN(1);
    loadPreStb = 1'b0;
    waitN(1);
  endtask

  task automatic hostAck(input string req);
    borrowAck = 1'b1;
    mCarry = 1'b0;
    expectAt(1, req);
    waitN(1);
    borrowAck = 1'b0;
    waitN(1);
  endtask

  // Monitor: compare each queued item in the cycle it falls due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      logic [2:0] ef;
      e = sbq.pop_front();
      ef = {e.cur > e.pre, e.cur == e.pre, e.cur < e.pre};
      checks++;
      if (curValue !== toBcd(e.cur) || presetValue !== toBcd(e.pre) ||
          carryFlag !== e.carry || {gtFlag, eqFlag, ltFlag} !== ef) begin
        fails++;
        $display("FAIL %s: cur=%h pre=%h carry=%b gt/eq/lt=%b expected cur=%h pre=%h carry=%b gt/eq/lt=%b",
                 e.req, curValue, presetValue, carryFlag, {gtFlag, eqFlag, ltFlag},
                 toBcd(e.cur), toBcd(e.pre), e.carry, ef);
      end
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    expectAt(0, "R1 reset state");
    waitN(2);

    hostPre(16'h0005, "R9 preset load");
    fieldPulse(0, "R2 up step");
    fieldPulse(0, "R2 up step");
    fieldPulse(0, "R2 up step");
    hostCur(16'h0005, "R8/R10 load equal to preset");
    fieldPulse(0, "R10 tally above preset");

    hostCur(16'h0199, "R8 tally load");
    fieldPulse(0, "R2 digit carry");
    fieldPulse(1, "R3 digit borrow");
    hostCur(16'h1000, "R8 tally load");
    fieldPulse(1, "R3 borrow across three digits");

    hostCur(16'h12A4, "R8 bad digit rejected");
    hostPre(16'h00F0, "R9 bad digit rejected");

    // Up pass through zero
    hostCur(16'h9999, "R8 tally load");
    fieldPulse(0, "R6 up wrap");
    fieldPulse(0, "R7 carry set by up pass");
    fieldPulse(0, "R7 carry stays set");
    hostAck("R7 carry acknowledged");

    // Down pass through zero
    hostCur(16'h0001, "R8 tally load");
    fieldPulse(1, "R3 step to zero");
    fieldPulse(1, "R7 borrow set by down pass");
    hostAck("R7 borrow acknowledged");

    // Zero entered by load, or left in the other direction: no flag
    hostCur(16'h0000, "R8 tally load");
    fieldPulse(1, "R6 R7 down wrap from loaded zero, no flag");
    hostCur(16'h0001, "R8 tally load");
    fieldPulse(1, "R3 step to zero");
    fieldPulse(0, "R7 turn back at zero, no flag");

    // Clear while up line held, then up edge masked by clear level
    hostCur(16'h4321, "R8 tally load");
    incIn = 1'b1; mStep(1);
    expectAt(3, "R2 up step");
    waitN(4);
    clrIn = 1'b1; mCur = 0; mEntry = 0;
    expectAt(3, "R5 clear with up line high");
    waitN(4);
    incIn = 1'b0;
    waitN(3);
    incIn = 1'b1;
    expectAt(4, "R4 up edge during clear level ignored");
    waitN(5);
    incIn = 1'b0; clrIn = 1'b0;
    waitN(3);

    // Up edge while down line held
    hostCur(16'h0050, "R8 tally load");
    decIn = 1'b1; mStep(-1);
    expectAt(3, "R3 down step");
    waitN(4);
    incIn = 1'b1;
    expectAt(4, "R4 up edge during down level ignored");
    waitN(5);
    incIn = 1'b0; decIn = 1'b0;
    waitN(3);

    // Coincident edges
    incIn = 1'b1; decIn = 1'b1;
    expectAt(4, "R4 coincident edges ignored");
    waitN(5);
    incIn = 1'b0; decIn = 1'b0;
    waitN(3);

    // Host load collides with a due up step
    incIn = 1'b1;
    waitN(2);
    loadValue = 16'h0777; loadCurStb = 1'b1; mCur = 777; mEntry = 0;
    expectAt(1, "R11 load wins over step");
    waitN(1);
    loadCurStb = 1'b0;
    expectAt(4, "R11 step dropped");
    waitN(5);
    incIn = 1'b0;
    waitN(3);

    // Rejected load still drops the step
    incIn = 1'b1;
    waitN(2);
    loadValue = 16'hB000; loadCurStb = 1'b1;
    expectAt(1, "R11 rejected load drops step");
    waitN(1);
    loadCurStb = 1'b0;
    expectAt(4, "R11 step stays dropped");
    waitN(5);
    incIn = 1'b0;
    waitN(3);

    hostPre(16'h9000, "R9 R10 preset above tally");

    waitN(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule